// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block runs the memory accesses of one instruction for an 8-bit processor with a 16-bit address space. It makes one bus access per clock. A pulse on `start` latches the program counter, a 3-bit addressing-mode code, a load/store class bit, an index byte and a store byte. The block then reads the opcode and the first operand byte. Depending on the mode it goes on to read an address high byte or two pointer bytes in page zero, and then reaches the target byte.

When an indexed address carries into its high byte, the block inserts an extra read at the address whose high byte has not yet been corrected. Stores in indexed modes always make this extra read, so a write never lands at the uncorrected address. The instruction length is not looked up in a table. It is the number of accesses the sequence actually makes, and it is reported together with the effective address and the loaded byte when `done` pulses.

Memory is asynchronous from the block's point of view: `bus_rdata` must hold the byte at `bus_addr` within the same cycle.

Top module: `bseq_top`

## Requirements
- R1: After a synchronous reset, `bus_active`, `bus_we` and `done` are low and `cycles` reads 0.
- R2: A `start` seen while idle makes the first access a read at `pc_in` and the second a read at `pc_in`+1, on consecutive cycles. A `start` seen while an instruction is running is ignored and does not change its accesses.
- R3: Mode code 0 (implied/accumulator) and mode code 1 (immediate) make exactly two accesses. For both, the effective address is `pc_in`+1, and a load returns the byte read there.
- R4: Mode code 2 (zero page) makes three accesses. The third goes to address {0x00, operand byte}.
- R5: Mode code 3 (absolute) makes four accesses. The third reads the high address byte at `pc_in`+2, and the target is {high, low}, with the low byte taken from `pc_in`+1.
- R6: Mode code 4 (absolute indexed) as a load makes four accesses when low+index does not exceed 0xFF. Otherwise it makes five, with a dummy read at {high, (low+index) mod 256} before the read at {high+1, (low+index) mod 256}.
- R7: Mode code 4 as a store always makes five accesses. The fourth is a read at {high, (low+index) mod 256}, and the fifth is a write at the corrected address.
- R8: Mode code 5 (page-zero pointer indexed by the index byte) as a load reads the pointer low byte at {0x00, p} and the pointer high byte at {0x00, (p+1) mod 256}. It then makes the data access, for five accesses in all, or six with a dummy read at the uncorrected address when the low byte carries.
- R9: Mode code 5 as a store always makes six accesses. The fifth is a read at the uncorrected address.
- R10: `bus_we` is high only on the final access of a store in mode codes 2 to 5, and `bus_wdata` then carries the latched store byte. A store class in mode codes 0 or 1 performs no write.
- R11: `done` is a one-cycle pulse in the cycle after the final access. `cycles` then equals the number of accesses, and `eff_addr` holds the final access address. `load_data` takes the final byte read only for the load class.
- R12: Mode codes 6 and 7 behave exactly as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| mode_sel | input | 3 | Addressing-mode code |
| store_op | input | 1 | 1 = store class, 0 = load class |
| pc_in | input | 16 | Address of the opcode |
| index_in | input | 8 | Index register value |
| store_data | input | 8 | Byte to write for a store |
| bus_addr | output | 16 | Memory address of the current access |
| bus_we | output | 1 | Write strobe for the current access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data for `bus_addr`, same cycle |
| bus_active | output | 1 | An access is made this cycle |
| done | output | 1 | Instruction finished pulse |
| eff_addr | output | 16 | Address of the final access |
| load_data | output | 8 | Byte read by the final access of a load |
| cycles | output | CNT_W | Number of accesses of the last instruction |

## Verification
The bench builds the block with its default counter width of four bits. The longest sequence is six accesses, so the count can be checked exactly with no wrap, and a count that is one too high or too low is still visible. The operands are chosen so that each indexed mode is run both with and without a carry into the high byte. A pointer at 0xFF exercises the wrap of the page-zero pointer fetch. Every access is compared against the reference queue on the clock where it happens.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        AM_IMPLIED  = 3'd0,
        AM_IMMED    = 3'd1,
        AM_ZPAGE    = 3'd2,
        AM_ABS      = 3'd3,
        AM_ABS_IDX  = 3'd4,
        AM_ZP_IND_Y = 3'd5
    } amode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_OPND,
        PH_ADDR_HI,
        PH_PTR_LO,
        PH_PTR_HI,
        PH_FIXUP,
        PH_TARGET
    } phase_e;

    // Operand bytes gathered during the sequence
    typedef struct packed {
        logic [DW-1:0] ptr;  // first operand byte (page-zero pointer)
        logic [DW-1:0] lo;   // base address low byte
        logic [DW-1:0] hi;   // base address high byte
    } opnd_t;

    function automatic amode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return AM_IMMED;
            3'd2:    return AM_ZPAGE;
            3'd3:    return AM_ABS;
            3'd4:    return AM_ABS_IDX;
            3'd5:    return AM_ZP_IND_Y;
            default: return AM_IMPLIED;
        endcase
    endfunction

    function automatic logic ends_after_operand(input amode_e m);
        return (m == AM_IMPLIED) || (m == AM_IMMED);
    endfunction

    function automatic logic uses_index(input amode_e m);
        return (m == AM_ABS_IDX) || (m == AM_ZP_IND_Y);
    endfunction

    function automatic logic [AW-1:0] join_addr(input logic [DW-1:0] hi,
                                                 input logic [DW-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode_in,
    input  logic             store_in,
    input  logic             carry,
    output phase_e           phase,
    output amode_e           mode_q,
    output logic             store_q,
    output logic             accept,
    output logic             last,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    phase_e phase_nx;
    logic   fix_needed;

    assign accept     = start && (phase == PH_IDLE);
    assign fix_needed = store_q || carry;
    assign last       = (phase == PH_TARGET) ||
                        ((phase == PH_OPND) && ends_after_operand(mode_q));

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:    phase_nx = accept ? PH_OPCODE : PH_IDLE;
            PH_OPCODE:  phase_nx = PH_OPND;
            PH_OPND: begin
                case (mode_q)
                    AM_ZPAGE:             phase_nx = PH_TARGET;
                    AM_ABS, AM_ABS_IDX:   phase_nx = PH_ADDR_HI;
                    AM_ZP_IND_Y:          phase_nx = PH_PTR_LO;
                    default:              phase_nx = PH_IDLE;
                endcase
            end
            PH_ADDR_HI: phase_nx = ((mode_q == AM_ABS_IDX) && fix_needed)
                                   ? PH_FIXUP : PH_TARGET;
            PH_PTR_LO:  phase_nx = PH_PTR_HI;
            PH_PTR_HI:  phase_nx = fix_needed ? PH_FIXUP : PH_TARGET;
            PH_FIXUP:   phase_nx = PH_TARGET;
            PH_TARGET:  phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            mode_q  <= AM_IMPLIED;
            store_q <= 1'b0;
            count   <= '0;
            done    <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase != PH_IDLE) && last;
            if (accept) begin
                mode_q  <= decode_mode(mode_in);
                store_q <= store_in;
                count   <= '0;
            end else if (phase != PH_IDLE) begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bseq_agen.sv
module bseq_agen
    import bseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  phase_e        phase,
    input  amode_e        mode_q,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] idx_in,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          carry
);

    localparam logic [DW-1:0] PAGE_ZERO = '0;

    logic [AW-1:0] pc_q;
    logic [DW-1:0] idx_q;
    opnd_t         op_q;
    logic [DW-1:0] idx_eff;
    logic [DW:0]   sum;
    logic [DW-1:0] hi_fixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            idx_q <= '0;
            op_q  <= '0;
        end else if (accept) begin
            pc_q  <= pc_in;
            idx_q <= idx_in;
        end else begin
            case (phase)
                PH_OPND: begin
                    op_q.ptr <= rdata;
                    op_q.lo  <= rdata;
                    op_q.hi  <= PAGE_ZERO;
                end
                PH_ADDR_HI: op_q.hi <= rdata;
                PH_PTR_LO:  op_q.lo <= rdata;
                PH_PTR_HI:  op_q.hi <= rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        idx_eff  = uses_index(mode_q) ? idx_q : '0;
        sum      = {1'b0, op_q.lo} + {1'b0, idx_eff};
        carry    = sum[DW];
        hi_fixed = op_q.hi + DW'(carry);
    end

    always_comb begin
        case (phase)
            PH_OPCODE:  addr = pc_q;
            PH_OPND:    addr = pc_q + AW'(1);
            PH_ADDR_HI: addr = pc_q + AW'(2);
            PH_PTR_LO:  addr = join_addr(PAGE_ZERO, op_q.ptr);
            PH_PTR_HI:  addr = join_addr(PAGE_ZERO, op_q.ptr + DW'(1));
            PH_FIXUP:   addr = join_addr(op_q.hi, sum[DW-1:0]);
            PH_TARGET:  addr = join_addr(hi_fixed, sum[DW-1:0]);
            default:    addr = pc_q;
        endcase
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode_sel,
    input  logic             store_op,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       index_in,
    input  logic [7:0]       store_data,
    output logic [15:0]      bus_addr,
    output logic             bus_we,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    output logic             bus_active,
    output logic             done,
    output logic [15:0]      eff_addr,
    output logic [7:0]       load_data,
    output logic [CNT_W-1:0] cycles
);

    phase_e        phase;
    amode_e        mode_q;
    logic          store_q;
    logic          accept;
    logic          last;
    logic          carry;
    logic [DW-1:0] wdata_q;

    bseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (mode_sel),
        .store_in (store_op),
        .carry    (carry),
        .phase    (phase),
        .mode_q   (mode_q),
        .store_q  (store_q),
        .accept   (accept),
        .last     (last),
        .count    (cycles),
        .done     (done)
    );

    bseq_agen u_agen (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .phase  (phase),
        .mode_q (mode_q),
        .pc_in  (pc_in),
        .idx_in (index_in),
        .rdata  (bus_rdata),
        .addr   (bus_addr),
        .carry  (carry)
    );

    assign bus_active = (phase != PH_IDLE);
    assign bus_we     = (phase == PH_TARGET) && store_q;
    assign bus_wdata  = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q   <= '0;
            eff_addr  <= '0;
            load_data <= '0;
        end else begin
            if (accept)
                wdata_q <= store_data;
            if (bus_active && last) begin
                eff_addr <= bus_addr;
                if (!store_q)
                    load_data <= bus_rdata;
            end
        end
    end

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [15:0]      pc_in,
    input logic [15:0]      bus_addr,
    input logic             bus_we,
    input logic             bus_active,
    input logic             done,
    input logic [CNT_W-1:0] cycles
);

    // R2: a start taken while idle fetches the opcode at pc_in next cycle
    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !bus_active) |=> (bus_active && bus_addr == $past(pc_in)));

    // R10: a write is always the final access
    assert_write_last_R10: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_active);

    // R10: a write is never the first access of an instruction
    assert_write_not_first_R10: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> $past(bus_active));

    // R11: done lasts one cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: count reported at done lies within two to six accesses, bus idle
    assert_done_count_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles >= CNT_W'(2) && cycles <= CNT_W'(6) && !bus_active));

endmodule

bind bseq_top bseq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pc_in      (pc_in),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_active (bus_active),
    .done       (done),
    .cycles     (cycles)
);

// File: tb/bseq_top_bench.sv
module bseq_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic        store;
    logic [15:0] pc;
    logic [7:0]  idx;
    logic [7:0]  sdata;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  rdata = 8'h00;
    logic        bus_active;
    logic        done;
    logic [15:0] eff_addr;
    logic [7:0]  load_data;
    logic [3:0]  cycles;

    always #10 clk = ~clk;

    bseq_top u_bseq_top (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode), .store_op(store),
        .pc_in(pc), .index_in(idx), .store_data(sdata),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .bus_active(bus_active), .done(done),
        .eff_addr(eff_addr), .load_data(load_data), .cycles(cycles)
    );

    typedef struct {
        logic [15:0] a;
        logic        w;
    } acc_t;

    logic [7:0] mem [int];
    acc_t       exp_q[$];
    acc_t       e_cur;
    int         seq_err;
    int         seq_seen;
    string      cur_req = "";
    int         n_tests = 0;
    int         n_fail  = 0;
    logic [7:0] last_ld = 8'h00;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (mem.exists(int'(a)))
            return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Behavioural memory and per-clock comparison of every bus access
    always @(negedge clk) begin
        if (!rst && bus_active) begin
            seq_seen++;
            if (exp_q.size() == 0) begin
                seq_err++;
                $display("  %s: unexpected access %0d at %h", cur_req, seq_seen, bus_addr);
            end else begin
                e_cur = exp_q.pop_front();
                if (e_cur.a !== bus_addr || e_cur.w !== bus_we) begin
                    seq_err++;
                    $display("  %s: access %0d got %h/%b want %h/%b", cur_req,
                             seq_seen, bus_addr, bus_we, e_cur.a, e_cur.w);
                end
            end
            if (bus_we)
                mem[int'(bus_addr)] = bus_wdata;
        end
        rdata <= mem_rd(bus_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic w);
        exp_q.push_back('{a: a, w: w});
    endtask

    task automatic run(input logic [2:0] m, input bit st, input logic [15:0] p,
                       input logic [7:0] x, input logic [7:0] d, input string req,
                       input bit poke = 1'b0);
        logic [15:0] fin;
        logic [7:0]  b1, hi, plo, phi, exp_ld;
        logic [8:0]  s;
        bit          wr;
        int          n_exp;
        int          t;
        exp_q.delete();
        seq_err  = 0;
        seq_seen = 0;
        cur_req  = req;
        wr = st && (m >= 3'd2) && (m <= 3'd5);
        push(p, 1'b0);
        push(p + 16'd1, 1'b0);
        b1 = mem_rd(p + 16'd1);
        case (m)
            3'd2: begin
                fin = {8'h00, b1};
                push(fin, wr);
            end
            3'd3: begin
                hi = mem_rd(p + 16'd2);
                push(p + 16'd2, 1'b0);
                fin = {hi, b1};
                push(fin, wr);
            end
            3'd4: begin
                hi = mem_rd(p + 16'd2);
                push(p + 16'd2, 1'b0);
                s = {1'b0, b1} + {1'b0, x};
                if (st || s[8]) push({hi, s[7:0]}, 1'b0);
                fin = {hi + {7'b0, s[8]}, s[7:0]};
                push(fin, wr);
            end
            3'd5: begin
                plo = mem_rd({8'h00, b1});
                phi = mem_rd({8'h00, b1 + 8'd1});
                push({8'h00, b1}, 1'b0);
                push({8'h00, b1 + 8'd1}, 1'b0);
                s = {1'b0, plo} + {1'b0, x};
                if (st || s[8]) push({phi, s[7:0]}, 1'b0);
                fin = {phi + {7'b0, s[8]}, s[7:0]};
                push(fin, wr);
            end
            default: fin = p + 16'd1;
        endcase
        exp_ld = st ? last_ld : mem_rd(fin);
        n_exp  = exp_q.size();

        @(negedge clk);
        mode = m; store = st; pc = p; idx = x; sdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            mode = 3'd0; store = 1'b1; pc = p + 16'h0100; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(done, req, "done seen", done, 1);
        chk(seq_err == 0 && exp_q.size() == 0, req, "access sequence",
            seq_err, 0);
        chk(cycles == 4'(n_exp), req, "cycle count", cycles, n_exp);
        chk(eff_addr == fin, req, "effective address", eff_addr, fin);
        chk(load_data == exp_ld, req, "load data", load_data, exp_ld);
        if (wr)
            chk(mem_rd(fin) == d, req, "stored byte", mem_rd(fin), d);
        last_ld = exp_ld;
        @(negedge clk);
        chk(!done, "R11", "done one cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected end)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = 3'd0; store = 1'b0;
        pc = 16'h0000; idx = 8'h00; sdata = 8'h00;
        // operand bytes
        mem[32'h0401] = 8'h40;                          // zp / imm operand
        mem[32'h0501] = 8'h34; mem[32'h0502] = 8'h12;   // abs
        mem[32'h0601] = 8'h10; mem[32'h0602] = 8'h22;   // abs idx, low 0x10
        mem[32'h0701] = 8'hF0; mem[32'h0702] = 8'h12;   // abs idx, low 0xF0
        mem[32'h0801] = 8'h80;                          // pointer 0x80
        mem[32'h0080] = 8'h20; mem[32'h0081] = 8'h30;
        mem[32'h0901] = 8'h90;                          // pointer 0x90
        mem[32'h0090] = 8'hE8; mem[32'h0091] = 8'h31;
        mem[32'h0A01] = 8'hFF;                          // pointer wraps
        mem[32'h00FF] = 8'h05; mem[32'h0000] = 8'h44;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_active && !bus_we && !done && cycles == 4'd0, "R1",
            "reset state", {bus_active, bus_we, done, cycles}, 0);

        run(3'd0, 1'b0, 16'h0300, 8'h00, 8'h00, "R3 implied");
        run(3'd1, 1'b0, 16'h0400, 8'h00, 8'h00, "R3 immediate");
        run(3'd0, 1'b1, 16'h0300, 8'h00, 8'h77, "R10 implied store no write");
        run(3'd1, 1'b1, 16'h0400, 8'h00, 8'h78, "R10 immediate store no write");
        run(3'd6, 1'b0, 16'h0310, 8'h00, 8'h00, "R12 code 6");
        run(3'd7, 1'b1, 16'h0320, 8'h00, 8'h00, "R12 code 7");
        run(3'd2, 1'b0, 16'h0400, 8'h00, 8'h00, "R4 zero page load");
        run(3'd2, 1'b1, 16'h0400, 8'h00, 8'h5C, "R4 zero page store");
        run(3'd3, 1'b0, 16'h0500, 8'h00, 8'h00, "R5 absolute load");
        run(3'd3, 1'b1, 16'h0500, 8'h00, 8'hC3, "R5 absolute store");
        run(3'd4, 1'b0, 16'h0600, 8'h20, 8'h00, "R6 indexed load no carry");
        run(3'd4, 1'b0, 16'h0700, 8'h20, 8'h00, "R6 indexed load carry");
        run(3'd4, 1'b0, 16'h0700, 8'h0F, 8'h00, "R6 indexed load edge 0xFF");
        run(3'd4, 1'b1, 16'h0600, 8'h20, 8'h9A, "R7 indexed store no carry");
        run(3'd4, 1'b1, 16'h0700, 8'h20, 8'h9B, "R7 indexed store carry");
        run(3'd5, 1'b0, 16'h0800, 8'h04, 8'h00, "R8 pointer load no carry");
        run(3'd5, 1'b0, 16'h0900, 8'h30, 8'h00, "R8 pointer load carry");
        run(3'd5, 1'b0, 16'h0A00, 8'h01, 8'h00, "R8 pointer wrap");
        run(3'd5, 1'b1, 16'h0800, 8'h04, 8'h6D, "R9 pointer store no carry");
        run(3'd5, 1'b1, 16'h0900, 8'h30, 8'h6E, "R9 pointer store carry");
        run(3'd3, 1'b0, 16'h0500, 8'h00, 8'h00, "R2 start while busy", 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule